// File: doc/BRIEF.md
# Colour DAC Host Register Port and Palette Loader

This block sits on the host side of a colour DAC. A narrow byte bus reaches it through four ports picked by a 2-bit select: an index port, a cursor colour port, an indirect register port and a palette data port. A single 8-bit index serves all three data ports. The index port sets it. Palette writes arrive as three bytes per entry (red, then green, then blue). Once the third byte arrives, the block issues a one-cycle palette write pulse carrying the entry number and the 24-bit colour, and the index moves on to the next entry. Cursor colour bytes go into a small local store at the index reduced modulo its depth, and each one also advances the index.

The indirect port reaches a few control registers through the same index: a 16-bit cursor position written as separate high and low bytes, the misc control register, a double-buffer control byte and a test control register. The block decodes the misc control register into a pixel width (8, 16 or 32 bits, with one illegal code), a clock divisor and an error flag. All outputs come from registers. A write shows at the outputs in the cycle after the edge that takes it, and read data appears one cycle after the read strobe.

Top module: `dac_host_regs`

## Requirements
- R1: After reset, pal_we is 0, cur_pos is 0, bus_rdata is 0, dac_test is 0, dbl_buf_ctrl is 0, pix_bits is 8, clk_div is 2 and depth_err is 0.
- R2: A write with bus_port = 0 loads the index with bus_wdata and clears the palette component count, so any partial entry is dropped.
- R3: On every third palette write (bus_port = 3) after the count was cleared, pal_we is 1 for exactly one cycle after that write's edge. In that cycle pal_index holds the index and pal_rgb holds {first, second, third byte}, the first byte in bits 23:16. The index then increments and wraps from 255 to 0.
- R4: The first and second palette writes of an entry produce no pal_we.
- R5: A cursor write (bus_port = 1) stores bus_wdata at location (index mod 24) and increments the index. The stored byte can be read on curc_rdata one cycle after curc_raddr selects it. Palette and cursor writes share and advance the same index.
- R6: An indirect write (bus_port = 2) with index 0x10 replaces cur_pos[15:8], and with index 0x11 it replaces cur_pos[7:0]. The other byte is kept.
- R7: A read with bus_port = 2 and index 0x20 returns the misc control register on bus_rdata in the cycle after the read. Any other index on that port, and any read of ports 0, 1 or 3, returns 0.
- R8: An indirect write to index 0x20 sets misc control. Its bits 3:2 select pix_bits: 0 gives 8, 1 gives 16, 2 gives 32, and 3 gives pix_bits 0 with depth_err 1. depth_err is 0 for the other codes.
- R9: clk_div equals 1 shifted left by (misc control bits 7:6 plus 1), giving 2, 4, 8 or 16.
- R10: An indirect write to index 0x22 sets dac_test to bit 0 of the data. An indirect write to index 0x21 loads dbl_buf_ctrl with the data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_port | input | 2 | Port select: 0 index, 1 cursor colour, 2 indirect, 3 palette |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| pal_we | output | 1 | Palette entry write pulse |
| pal_index | output | 8 | Palette entry number |
| pal_rgb | output | 24 | Palette colour, red in 23:16 |
| curc_raddr | input | 5 | Cursor colour store read address |
| curc_rdata | output | 8 | Cursor colour store read data |
| cur_pos | output | 16 | Cursor position |
| dbl_buf_ctrl | output | 8 | Double-buffer control byte |
| dac_test | output | 1 | DAC test mode enable |
| pix_bits | output | 6 | Decoded pixel width in bits, 0 if illegal |
| clk_div | output | 5 | Decoded clock divisor |
| depth_err | output | 1 | Illegal pixel depth code |

## Verification
The hardest case to reach is a palette sequence whose component count gets cut short by an index write, or whose index wraps past 255, when cursor writes are moving the same index in between. The stimulus mixes palette bytes, cursor bytes and random index writes in a seeded random stream and tracks the index and the component count in a bench model. Directed cases start at index 255 and at an index that makes the cursor location wrap modulo 24. At the end the cursor store is read back over its full depth.

// File: rtl/dac_host_pkg.sv
package dac_host_pkg;
  localparam logic [1:0] PORT_ADDR = 2'd0;
  localparam logic [1:0] PORT_CURS = 2'd1;
  localparam logic [1:0] PORT_IND  = 2'd2;
  localparam logic [1:0] PORT_PAL  = 2'd3;

  localparam logic [7:0] IX_CPOS_HI = 8'h10;
  localparam logic [7:0] IX_CPOS_LO = 8'h11;
  localparam logic [7:0] IX_MISC    = 8'h20;
  localparam logic [7:0] IX_DBUF    = 8'h21;
  localparam logic [7:0] IX_TEST    = 8'h22;

  // pixel width in bits for a depth code; 0 marks the illegal code
  function automatic logic [5:0] depth_bits_of(input logic [1:0] code);
    case (code)
      2'd0:    return 6'd8;
      2'd1:    return 6'd16;
      2'd2:    return 6'd32;
      default: return 6'd0;
    endcase
  endfunction
endpackage

// File: rtl/dac_index_ctrl.sv
module dac_index_ctrl #(
  parameter int IW    = 8,
  parameter int NCOMP = 3,
  localparam int CSW  = $clog2(NCOMP)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           addr_we,
  input  logic           curs_we,
  input  logic           pal_we_in,
  input  logic [IW-1:0]  wdata,
  output logic [IW-1:0]  idx,
  output logic [CSW-1:0] comp_sel,
  output logic           comp_last
);
  assign comp_last = (comp_sel == CSW'(NCOMP - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      idx      <= '0;
      comp_sel <= '0;
    end else if (addr_we) begin
      idx      <= wdata;
      comp_sel <= '0;
    end else if (curs_we) begin
      idx <= idx + 1'b1;
    end else if (pal_we_in) begin
      if (comp_last) begin
        comp_sel <= '0;
        idx      <= idx + 1'b1;
      end else begin
        comp_sel <= comp_sel + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dac_palette_asm.sv
module dac_palette_asm #(
  parameter int CW    = 8,
  parameter int IW    = 8,
  parameter int NCOMP = 3,
  localparam int CSW  = $clog2(NCOMP)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr,
  input  logic [CW-1:0]       wdata,
  input  logic [CSW-1:0]      comp_sel,
  input  logic                comp_last,
  input  logic [IW-1:0]       idx,
  output logic                commit,
  output logic [IW-1:0]       commit_idx,
  output logic [NCOMP*CW-1:0] commit_rgb
);
  logic [CW-1:0] hold [NCOMP-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      commit     <= 1'b0;
      commit_idx <= '0;
      commit_rgb <= '0;
      for (int i = 0; i < NCOMP - 1; i++) hold[i] <= '0;
    end else begin
      commit <= wr && comp_last;
      if (wr && !comp_last) begin
        for (int i = 0; i < NCOMP - 1; i++)
          if (comp_sel == CSW'(i)) hold[i] <= wdata;
      end
      if (wr && comp_last) begin
        commit_idx <= idx;
        for (int i = 0; i < NCOMP - 1; i++)
          commit_rgb[(NCOMP-1-i)*CW +: CW] <= hold[i];
        commit_rgb[CW-1:0] <= wdata;
      end
    end
  end
endmodule

// File: rtl/dac_cursor_ram.sv
module dac_cursor_ram #(
  parameter int DEPTH = 24,
  parameter int DW    = 8,
  parameter int IW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];
  logic [IW-1:0] wpos;

  assign wpos = widx % IW'(DEPTH);

  always_ff @(posedge clk) begin
    if (wr) mem[wpos[AW-1:0]] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dac_ctrl_regs.sv
module dac_ctrl_regs
  import dac_host_pkg::*;
#(
  parameter int DW  = 8,
  parameter int PW  = 16,
  parameter int CDW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ind_we,
  input  logic           rd,
  input  logic [1:0]     port,
  input  logic [DW-1:0]  idx,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  output logic [PW-1:0]  cur_pos,
  output logic [DW-1:0]  dbl_buf,
  output logic           test_en,
  output logic [5:0]     pix_bits,
  output logic [CDW-1:0] clk_div,
  output logic           depth_err
);
  logic [DW-1:0] misc;

  always_ff @(posedge clk) begin
    if (rst) begin
      misc      <= '0;
      cur_pos   <= '0;
      dbl_buf   <= '0;
      test_en   <= 1'b0;
      pix_bits  <= depth_bits_of(2'd0);
      clk_div   <= CDW'(2);
      depth_err <= 1'b0;
    end else if (ind_we) begin
      case (idx)
        IX_CPOS_HI: cur_pos[PW-1:DW] <= wdata;
        IX_CPOS_LO: cur_pos[DW-1:0]  <= wdata;
        IX_MISC: begin
          misc      <= wdata;
          pix_bits  <= depth_bits_of(wdata[3:2]);
          depth_err <= (wdata[3:2] == 2'd3);
          clk_div   <= CDW'(2) << wdata[7:6];
        end
        IX_DBUF: dbl_buf <= wdata;
        IX_TEST: test_en <= wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd) rdata <= (port == PORT_IND && idx == IX_MISC) ? misc : '0;
  end
endmodule

// File: rtl/dac_host_regs.sv
module dac_host_regs
  import dac_host_pkg::*;
#(
  parameter int DW         = 8,
  parameter int NCOMP      = 3,
  parameter int CURS_BYTES = 24,
  parameter int CDW        = 5,
  localparam int CSW       = $clog2(NCOMP),
  localparam int CAW       = $clog2(CURS_BYTES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [1:0]          bus_port,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  output logic                pal_we,
  output logic [DW-1:0]       pal_index,
  output logic [NCOMP*DW-1:0] pal_rgb,
  input  logic [CAW-1:0]      curc_raddr,
  output logic [DW-1:0]       curc_rdata,
  output logic [2*DW-1:0]     cur_pos,
  output logic [DW-1:0]       dbl_buf_ctrl,
  output logic                dac_test,
  output logic [5:0]          pix_bits,
  output logic [CDW-1:0]      clk_div,
  output logic                depth_err
);
  logic           wr_addr, wr_curs, wr_ind, wr_pal;
  logic [DW-1:0]  idx;
  logic [CSW-1:0] comp_sel;
  logic           comp_last;

  assign wr_addr = bus_wr && (bus_port == PORT_ADDR);
  assign wr_curs = bus_wr && (bus_port == PORT_CURS);
  assign wr_ind  = bus_wr && (bus_port == PORT_IND);
  assign wr_pal  = bus_wr && (bus_port == PORT_PAL);

  dac_index_ctrl #(.IW(DW), .NCOMP(NCOMP)) u_index (
    .clk(clk), .rst(rst), .addr_we(wr_addr), .curs_we(wr_curs),
    .pal_we_in(wr_pal), .wdata(bus_wdata), .idx(idx),
    .comp_sel(comp_sel), .comp_last(comp_last)
  );

  dac_palette_asm #(.CW(DW), .IW(DW), .NCOMP(NCOMP)) u_pal (
    .clk(clk), .rst(rst), .wr(wr_pal), .wdata(bus_wdata),
    .comp_sel(comp_sel), .comp_last(comp_last), .idx(idx),
    .commit(pal_we), .commit_idx(pal_index), .commit_rgb(pal_rgb)
  );

  dac_cursor_ram #(.DEPTH(CURS_BYTES), .DW(DW), .IW(DW)) u_curs (
    .clk(clk), .wr(wr_curs), .widx(idx), .wdata(bus_wdata),
    .raddr(curc_raddr), .rdata(curc_rdata)
  );

  dac_ctrl_regs #(.DW(DW), .PW(2*DW), .CDW(CDW)) u_ctrl (
    .clk(clk), .rst(rst), .ind_we(wr_ind), .rd(bus_rd), .port(bus_port),
    .idx(idx), .wdata(bus_wdata), .rdata(bus_rdata), .cur_pos(cur_pos),
    .dbl_buf(dbl_buf_ctrl), .test_en(dac_test), .pix_bits(pix_bits),
    .clk_div(clk_div), .depth_err(depth_err)
  );
endmodule

// File: rtl/dac_host_regs_chk.sv
module dac_host_regs_chk #(
  parameter int CDW = 5
) (
  input logic           clk,
  input logic           rst,
  input logic           bus_wr,
  input logic           bus_rd,
  input logic [1:0]     bus_port,
  input logic [7:0]     bus_rdata,
  input logic           pal_we,
  input logic [15:0]    cur_pos,
  input logic           dac_test,
  input logic           depth_err,
  input logic [CDW-1:0] clk_div
);
  // R3: commit is a single-cycle pulse
  p_pal_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    pal_we |=> !pal_we);

  // R4: a commit only follows a palette port write
  p_pal_src_r4: assert property (@(posedge clk) disable iff (rst)
    pal_we |-> $past(bus_wr && bus_port == 2'd3));

  // R6: cursor position moves only on indirect writes
  p_cpos_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_port == 2'd2) |=> $stable(cur_pos));

  // R7: reads outside the indirect port return zero
  p_rd_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_port != 2'd2) |=> (bus_rdata == 8'd0));

  // R8: error flag changes only on an indirect write
  p_err_src_r8: assert property (@(posedge clk) disable iff (rst)
    (depth_err != $past(depth_err)) |-> $past(bus_wr && bus_port == 2'd2));

  // R9: divisor is a single power of two, at least 2
  p_div_pow2_r9: assert property (@(posedge clk) disable iff (rst)
    ($countones(clk_div) == 1) && !clk_div[0]);

  // R10: test mode changes only on an indirect write
  p_test_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_port == 2'd2) |=> $stable(dac_test));
endmodule

bind dac_host_regs dac_host_regs_chk #(.CDW(CDW)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_port(bus_port), .bus_rdata(bus_rdata), .pal_we(pal_we),
  .cur_pos(cur_pos), .dac_test(dac_test), .depth_err(depth_err),
  .clk_div(clk_div)
);

// File: tb/dac_host_regs_tb.sv
module dac_host_regs_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_port = 2'd0;
  logic [7:0]  bus_wdata = 8'd0;
  logic [7:0]  bus_rdata;
  logic        pal_we;
  logic [7:0]  pal_index;
  logic [23:0] pal_rgb;
  logic [4:0]  curc_raddr = 5'd0;
  logic [7:0]  curc_rdata;
  logic [15:0] cur_pos;
  logic [7:0]  dbl_buf_ctrl;
  logic        dac_test;
  logic [5:0]  pix_bits;
  logic [4:0]  clk_div;
  logic        depth_err;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [7:0] m_idx = 8'd0;
  int         m_comp = 0;
  logic [7:0] m_hold [2];
  logic [7:0] m_curs [24];
  bit         m_cval [24];

  always #2 clk = ~clk;

  dac_host_regs u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_port(bus_port), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pal_we(pal_we), .pal_index(pal_index), .pal_rgb(pal_rgb),
    .curc_raddr(curc_raddr), .curc_rdata(curc_rdata), .cur_pos(cur_pos),
    .dbl_buf_ctrl(dbl_buf_ctrl), .dac_test(dac_test), .pix_bits(pix_bits),
    .clk_div(clk_div), .depth_err(depth_err)
  );

  function automatic logic [5:0] exp_bits(input logic [1:0] c);
    return (c == 2'd0) ? 6'd8 : (c == 2'd1) ? 6'd16 : (c == 2'd2) ? 6'd32 : 6'd0;
  endfunction

  function automatic logic [4:0] exp_div(input logic [1:0] c);
    return 5'(1 << (int'(c) + 1));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] p, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_port = p; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] p, output logic [7:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_port = p;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic addr_wr(input logic [7:0] d);
    bus_write(2'd0, d);
    m_idx = d; m_comp = 0;
  endtask

  task automatic pal_wr(input logic [7:0] d);
    bus_write(2'd3, d);
    if (m_comp == 2) begin
      check("R3 pal_we", {31'd0, pal_we}, 32'd1);
      check("R3 pal_index", {24'd0, pal_index}, {24'd0, m_idx});
      check("R3 pal_rgb", {8'd0, pal_rgb}, {8'd0, m_hold[0], m_hold[1], d});
      m_idx = m_idx + 8'd1; m_comp = 0;
    end else begin
      check("R4 no pal_we", {31'd0, pal_we}, 32'd0);
      m_hold[m_comp] = d; m_comp++;
    end
  endtask

  task automatic curs_wr(input logic [7:0] d);
    bus_write(2'd1, d);
    m_curs[int'(m_idx) % 24] = d;
    m_cval[int'(m_idx) % 24] = 1'b1;
    m_idx = m_idx + 8'd1;
  endtask

  task automatic ind_wr(input logic [7:0] ix, input logic [7:0] d);
    addr_wr(ix);
    bus_write(2'd2, d);
  endtask

  task automatic curs_readback();
    for (int i = 0; i < 24; i++) begin
      @(negedge clk); curc_raddr = 5'(i);
      @(negedge clk);
      if (m_cval[i]) check("R5 cursor store", {24'd0, curc_rdata}, {24'd0, m_curs[i]});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, m;
    for (int i = 0; i < 24; i++) m_cval[i] = 1'b0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 pal_we", {31'd0, pal_we}, 32'd0);
    check("R1 cur_pos", {16'd0, cur_pos}, 32'd0);
    check("R1 rdata", {24'd0, bus_rdata}, 32'd0);
    check("R1 dac_test", {31'd0, dac_test}, 32'd0);
    check("R1 dbl_buf", {24'd0, dbl_buf_ctrl}, 32'd0);
    check("R1 pix_bits", {26'd0, pix_bits}, 32'd8);
    check("R1 clk_div", {27'd0, clk_div}, 32'd2);
    check("R1 depth_err", {31'd0, depth_err}, 32'd0);

    // R2: index write drops a partial entry
    addr_wr(8'd5); pal_wr(8'h11);
    addr_wr(8'd7); pal_wr(8'hA1); pal_wr(8'hB2); pal_wr(8'hC3);
    check("R2 index after restart", {24'd0, pal_index}, 32'd7);
    // R3: wrap 255 -> 0
    addr_wr(8'd255);
    pal_wr(8'h01); pal_wr(8'h02); pal_wr(8'h03);
    pal_wr(8'h04); pal_wr(8'h05); pal_wr(8'h06);
    check("R3 wrapped index", {24'd0, pal_index}, 32'd0);
    // R5: cursor modulo 24 and shared index
    addr_wr(8'd22);
    curs_wr(8'h31); curs_wr(8'h32); curs_wr(8'h33); curs_wr(8'h34);
    addr_wr(8'd30); curs_wr(8'h55);
    pal_wr(8'h10); pal_wr(8'h20); pal_wr(8'h30);
    check("R5 shared index", {24'd0, pal_index}, 32'd31);
    curs_readback();

    // R6 cursor position
    ind_wr(8'h10, 8'hAB);
    check("R6 high byte", {16'd0, cur_pos}, 32'h0000AB00);
    ind_wr(8'h11, 8'hCD);
    check("R6 low byte", {16'd0, cur_pos}, 32'h0000ABCD);

    // R8 R9 R7 misc decode and readback
    for (int d = 0; d < 4; d++) begin
      for (int c = 0; c < 4; c++) begin
        m = {2'(c), 2'($urandom), 2'(d), 2'($urandom)};
        ind_wr(8'h20, m);
        check("R8 pix_bits", {26'd0, pix_bits}, {26'd0, exp_bits(2'(d))});
        check("R8 depth_err", {31'd0, depth_err}, {31'd0, d == 3});
        check("R9 clk_div", {27'd0, clk_div}, {27'd0, exp_div(2'(c))});
        bus_read(2'd2, v);
        check("R7 misc readback", {24'd0, v}, {24'd0, m});
      end
    end
    addr_wr(8'h10);
    bus_read(2'd2, v);
    check("R7 other indirect reads 0", {24'd0, v}, 32'd0);
    addr_wr(8'h20);
    bus_read(2'd3, v);
    check("R7 palette port reads 0", {24'd0, v}, 32'd0);
    bus_read(2'd1, v);
    check("R7 cursor port reads 0", {24'd0, v}, 32'd0);

    // R10 test and double-buffer control
    ind_wr(8'h22, 8'h01);
    check("R10 test on", {31'd0, dac_test}, 32'd1);
    ind_wr(8'h22, 8'hFE);
    check("R10 test off", {31'd0, dac_test}, 32'd0);
    ind_wr(8'h21, 8'h5A);
    check("R10 dbl_buf", {24'd0, dbl_buf_ctrl}, 32'h5A);
    check("R6 position kept", {16'd0, cur_pos}, 32'h0000ABCD);

    // random mix of palette, cursor and index writes
    for (int n = 0; n < 600; n++) begin
      int op;
      op = int'($urandom % 10);
      if (op < 6)      pal_wr(8'($urandom));
      else if (op < 9) curs_wr(8'($urandom));
      else             addr_wr(8'($urandom));
    end
    curs_readback();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule